// File: doc/BRIEF.md
# Guarded Ring-Oscillator Control Register Bank

This block is an APB slave that holds the control settings of an on-chip ring oscillator. Every writable field only accepts particular code words. A write that carries any other code does not load that value: the field takes a defined safe setting, or keeps its current one, and a sticky bad-write flag is raised. Software clears the flag by writing a one to it.

The decoded settings leave the block as plain control signals:
- an oscillator enable;
- a ring-length select, given both as a range index and as the first active stage;
- two banks of per-stage drive strengths;
- a pause request;
- a post-divider value;
- the phase-shifted output controls.

Three status inputs from the oscillator are read back in a status word: stable, enabled and divider running. The ring, the divider datapath and any wake interrupt are outside this block.

Top module: `ring_osc_regs`

## Requirements
- R1: After reset the outputs are as follows. `osc_en`=1. The range is the longest ring (`range_sel`=0, `stage_first`=0). Both drive banks are 0. `dormant_req`=0. `div_val`=16. `phase_en`=1, `phase_flip`=0 and `phase_shift`=0. The bad-write flag is 0.
- R2: A write to word 0x00 decodes bits [23:12] as follows. 0xD1E clears `osc_en` and 0xFAB sets it. Any other value sets `osc_en` and raises bad-write.
- R3: A write to word 0x00 decodes bits [11:0] as a Gray-coded range:
  - 0xFA4 gives `range_sel`=0 and `stage_first`=0.
  - 0xFA5 gives 1 and 2.
  - 0xFA7 gives 2 and 4.
  - 0xFA6 gives 3 and 6.
  - Any other value leaves the range unchanged and raises bad-write.
- R4: A write to word 0x04 whose bits [31:16] equal 0x9696 loads the drive strengths of stages 0..3. Word 0x08 does the same for stages 4..7. Within a word, stage k (counted from the word's first stage) is taken from bits [4k+2:4k]. It appears on `drive_lo` or `drive_hi` at bits [3k+2:3k]. Reading either word returns the four fields at the same bit positions, with the other bits 0.
- R5: A write to word 0x04 or 0x08 with any other value in [31:16] sets all four drive strengths of that word to 0 and raises bad-write. The other bank is not touched.
- R6: A write to word 0x0C is decoded as follows. 0x636F6D61 sets `dormant_req` and 0x77616B65 clears it. Any other value clears it and raises bad-write. A read returns the code of the current state.
- R7: A write to word 0x10 with bits [11:0] in 0xAA0..0xAAF or 0xAB0..0xABF loads `div_val` from bits [4:0]; `div_val`=0 stands for divide by 32. Any other value loads 31 and raises bad-write. A read returns 0xAA0 + `div_val`.
- R8: A write to word 0x14 with bits [11:4] = 0xAA loads `phase_en` from bit 3, `phase_flip` from bit 2 and `phase_shift` from bits [1:0]. Any other value in [11:4] gives enable 1, flip 0 and shift 0, and raises bad-write. A read returns those four bits in [3:0], with 0 above.
- R9: Word 0x18 reads `osc_stable` at bit 31, bad-write at bit 24, `div_running` at bit 16 and `osc_enabled` at bit 12, with 0 elsewhere. Writing 1 to bit 24 clears bad-write. Writing 0 there leaves it as it is.
- R10: Two kinds of address are ignored: words at 0x1C and above, and any address with bits [1:0] not zero. Reads of them return 0 and writes to them change nothing. `pready` is always 1 and `pslverr` always 0.
- R11: A read of word 0x00 returns the 24 bits last written there, including invalid codes. The reset value is 0x000AA0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| osc_stable | input | 1 | Oscillator running and stable |
| osc_enabled | input | 1 | Oscillator enabled |
| div_running | input | 1 | Post-divider running |
| osc_en | output | 1 | Oscillator enable |
| range_sel | output | 2 | Range index, 0 longest ring to 3 shortest |
| stage_first | output | 3 | First active ring stage |
| drive_lo | output | 12 | Drive strengths, stages 0..3 |
| drive_hi | output | 12 | Drive strengths, stages 4..7 |
| dormant_req | output | 1 | Pause request |
| div_val | output | 5 | Divider setting, 0 means 32 |
| phase_en | output | 1 | Phase output enable |
| phase_flip | output | 1 | Phase output invert |
| phase_shift | output | 2 | Phase shift in input clocks |

## Verification
The hardest case is telling "field kept its old value" apart from "field fell back to its default" after a bad code. To see the difference, the field must first be moved away from its default. The stimulus therefore sets the range to the high setting before writing an invalid range code. It also loads the upper drive bank before a bad password is written to the lower bank. Because the bad-write flag is sticky, each case must start from a clean flag, so the stimulus clears the flag and checks it before every vector. That way each raise is attributed to the one write that caused it.

// File: rtl/ring_osc_regs.sv
module ring_osc_regs #(
  parameter int ADDR_W = 8,
  parameter int STAGES = 8,
  parameter int DS_W   = 3
) (
  input  logic                      pclk,
  input  logic                      presetn,
  input  logic                      psel,
  input  logic                      penable,
  input  logic                      pwrite,
  input  logic [ADDR_W-1:0]         paddr,
  input  logic [31:0]               pwdata,
  output logic [31:0]               prdata,
  output logic                      pready,
  output logic                      pslverr,
  input  logic                      osc_stable,
  input  logic                      osc_enabled,
  input  logic                      div_running,
  output logic                      osc_en,
  output logic [1:0]                range_sel,
  output logic [2:0]                stage_first,
  output logic [STAGES/2*DS_W-1:0]  drive_lo,
  output logic [STAGES/2*DS_W-1:0]  drive_hi,
  output logic                      dormant_req,
  output logic [4:0]                div_val,
  output logic                      phase_en,
  output logic                      phase_flip,
  output logic [1:0]                phase_shift
);
  localparam int BANK  = STAGES / 2;
  localparam int SLOT  = DS_W + 1;
  localparam int DRV_W = BANK * DS_W;
  localparam int IDX_W = ADDR_W - 2;

  localparam logic [11:0] EN_OFF     = 12'hD1E;
  localparam logic [11:0] EN_ON      = 12'hFAB;
  localparam logic [9:0]  RNG_BASE   = 10'h3E9;
  localparam logic [15:0] DRV_KEY    = 16'h9696;
  localparam logic [31:0] SLEEP_CODE = 32'h636F6D61;
  localparam logic [31:0] WAKE_CODE  = 32'h77616B65;
  localparam logic [6:0]  DIV_BASE   = 7'h55;
  localparam logic [7:0]  PH_KEY     = 8'hAA;

  logic [23:0]      ctl_raw_q;
  logic             en_q;
  logic [1:0]       rng_q;
  logic [DRV_W-1:0] dlo_q, dhi_q;
  logic             dorm_q;
  logic [4:0]       div_q;
  logic             ph_en_q, ph_flip_q;
  logic [1:0]       ph_shift_q;
  logic             bad_q;

  logic [IDX_W-1:0] widx;
  logic             aligned, wr, rd;
  logic             hit_ctl, hit_dlo, hit_dhi, hit_slp, hit_div, hit_ph, hit_sts;

  assign widx    = paddr[ADDR_W-1:2];
  assign aligned = (paddr[1:0] == 2'b00);
  assign wr      = psel & penable & pwrite & aligned;
  assign rd      = psel & ~pwrite & aligned;

  assign hit_ctl = (widx == IDX_W'(0));
  assign hit_dlo = (widx == IDX_W'(1));
  assign hit_dhi = (widx == IDX_W'(2));
  assign hit_slp = (widx == IDX_W'(3));
  assign hit_div = (widx == IDX_W'(4));
  assign hit_ph  = (widx == IDX_W'(5));
  assign hit_sts = (widx == IDX_W'(6));

  logic       en_code_ok, rng_ok, drv_ok, slp_ok, div_ok, ph_ok;
  logic [1:0] rng_new;

  assign en_code_ok = (pwdata[23:12] == EN_OFF) | (pwdata[23:12] == EN_ON);
  assign rng_ok     = (pwdata[11:2] == RNG_BASE);
  assign rng_new    = {pwdata[1], pwdata[1] ^ pwdata[0]};
  assign drv_ok     = (pwdata[31:16] == DRV_KEY);
  assign slp_ok     = (pwdata == SLEEP_CODE) | (pwdata == WAKE_CODE);
  assign div_ok     = (pwdata[11:5] == DIV_BASE);
  assign ph_ok      = (pwdata[11:4] == PH_KEY);

  logic [DRV_W-1:0] drv_in;
  logic [15:0]      dlo_rd, dhi_rd;

  for (genvar s = 0; s < BANK; s++) begin : g_stage
    assign drv_in[s*DS_W +: DS_W]   = drv_ok ? pwdata[s*SLOT +: DS_W] : '0;
    assign dlo_rd[s*SLOT +: SLOT]   = {1'b0, dlo_q[s*DS_W +: DS_W]};
    assign dhi_rd[s*SLOT +: SLOT]   = {1'b0, dhi_q[s*DS_W +: DS_W]};
  end

  logic bad_evt, bad_clr;

  assign bad_evt = wr & ((hit_ctl & (~en_code_ok | ~rng_ok)) |
                         ((hit_dlo | hit_dhi) & ~drv_ok) |
                         (hit_slp & ~slp_ok) |
                         (hit_div & ~div_ok) |
                         (hit_ph & ~ph_ok));
  assign bad_clr = wr & hit_sts & pwdata[24];

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      ctl_raw_q  <= 24'h000AA0;
      en_q       <= 1'b1;
      rng_q      <= 2'd0;
      dlo_q      <= '0;
      dhi_q      <= '0;
      dorm_q     <= 1'b0;
      div_q      <= 5'd16;
      ph_en_q    <= 1'b1;
      ph_flip_q  <= 1'b0;
      ph_shift_q <= 2'd0;
      bad_q      <= 1'b0;
    end else begin
      if (wr && hit_ctl) begin
        ctl_raw_q <= pwdata[23:0];
        en_q      <= (pwdata[23:12] != EN_OFF);
        if (rng_ok) rng_q <= rng_new;
      end
      if (wr && hit_dlo) dlo_q <= drv_in;
      if (wr && hit_dhi) dhi_q <= drv_in;
      if (wr && hit_slp) dorm_q <= (pwdata == SLEEP_CODE);
      if (wr && hit_div) div_q <= div_ok ? pwdata[4:0] : 5'd31;
      if (wr && hit_ph) begin
        ph_en_q    <= ph_ok ? pwdata[3] : 1'b1;
        ph_flip_q  <= ph_ok & pwdata[2];
        ph_shift_q <= ph_ok ? pwdata[1:0] : 2'd0;
      end
      if (bad_evt)      bad_q <= 1'b1;
      else if (bad_clr) bad_q <= 1'b0;
    end
  end

  always_comb begin
    prdata = '0;
    if (rd) begin
      unique case (1'b1)
        hit_ctl: prdata = {8'h00, ctl_raw_q};
        hit_dlo: prdata = {16'h0000, dlo_rd};
        hit_dhi: prdata = {16'h0000, dhi_rd};
        hit_slp: prdata = dorm_q ? SLEEP_CODE : WAKE_CODE;
        hit_div: prdata = {20'h0, 12'hAA0 + {7'h0, div_q}};
        hit_ph:  prdata = {28'h0, ph_en_q, ph_flip_q, ph_shift_q};
        hit_sts: prdata = {osc_stable, 6'h0, bad_q, 7'h0, div_running,
                           3'h0, osc_enabled, 12'h000};
        default: prdata = '0;
      endcase
    end
  end

  assign pready      = 1'b1;
  assign pslverr     = 1'b0;
  assign osc_en      = en_q;
  assign range_sel   = rng_q;
  assign stage_first = {rng_q, 1'b0};
  assign drive_lo    = dlo_q;
  assign drive_hi    = dhi_q;
  assign dormant_req = dorm_q;
  assign div_val     = div_q;
  assign phase_en    = ph_en_q;
  assign phase_flip  = ph_flip_q;
  assign phase_shift = ph_shift_q;
endmodule

// File: rtl/ring_osc_regs_chk.sv
module ring_osc_regs_chk #(
  parameter int ADDR_W = 8,
  parameter int DRV_W  = 12
) (
  input logic              pclk,
  input logic              presetn,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [31:0]       pwdata,
  input logic              pready,
  input logic              pslverr,
  input logic              osc_en,
  input logic [1:0]        range_sel,
  input logic [DRV_W-1:0]  drive_lo,
  input logic              dormant_req,
  input logic [4:0]        div_val,
  input logic              bad_flag
);
  logic wr_now;
  assign wr_now = psel && penable && pwrite && (paddr[1:0] == 2'b00);

  function automatic logic at(input logic [ADDR_W-1:0] a, input int word);
    return a[ADDR_W-1:2] == (ADDR_W-2)'(word);
  endfunction

  // R10
  bus_resp_chk: assert property (@(posedge pclk) disable iff (!presetn)
    pready && !pslverr);

  // R2
  en_off_chk: assert property (@(posedge pclk) disable iff (!presetn)
    wr_now && at(paddr, 0) && pwdata[23:12] == 12'hD1E |=> !osc_en);

  // R3
  rng_hold_chk: assert property (@(posedge pclk) disable iff (!presetn)
    wr_now && at(paddr, 0) && pwdata[11:2] != 10'h3E9 |=> $stable(range_sel) && bad_flag);

  // R5
  drv_pw_chk: assert property (@(posedge pclk) disable iff (!presetn)
    wr_now && at(paddr, 1) && pwdata[31:16] != 16'h9696 |=> drive_lo == '0 && bad_flag);

  // R6
  wake_chk: assert property (@(posedge pclk) disable iff (!presetn)
    wr_now && at(paddr, 3) && pwdata != 32'h636F6D61 |=> !dormant_req);

  // R7
  div_bad_chk: assert property (@(posedge pclk) disable iff (!presetn)
    wr_now && at(paddr, 4) && pwdata[11:5] != 7'h55 |=> div_val == 5'd31 && bad_flag);

  // R9
  bad_clr_chk: assert property (@(posedge pclk) disable iff (!presetn)
    wr_now && at(paddr, 6) && pwdata[24] |=> !bad_flag);
endmodule

bind ring_osc_regs ring_osc_regs_chk #(.ADDR_W(ADDR_W), .DRV_W(STAGES/2*DS_W)) u_chk (
  .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .pready(pready), .pslverr(pslverr),
  .osc_en(osc_en), .range_sel(range_sel), .drive_lo(drive_lo),
  .dormant_req(dormant_req), .div_val(div_val), .bad_flag(bad_q)
);

// File: tb/ring_osc_regs_bench.sv
`timescale 1ns/100ps
module ring_osc_regs_bench;
  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic        osc_stable = 1'b0, osc_enabled = 1'b0, div_running = 1'b0;
  logic        osc_en, dormant_req, phase_en, phase_flip;
  logic [1:0]  range_sel, phase_shift;
  logic [2:0]  stage_first;
  logic [11:0] drive_lo, drive_hi;
  logic [4:0]  div_val;

  int total = 0;
  int bad = 0;

  always #2.5 pclk = ~pclk;

  ring_osc_regs u_ring_osc_regs (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
    .osc_stable(osc_stable), .osc_enabled(osc_enabled), .div_running(div_running),
    .osc_en(osc_en), .range_sel(range_sel), .stage_first(stage_first),
    .drive_lo(drive_lo), .drive_hi(drive_hi), .dormant_req(dormant_req),
    .div_val(div_val), .phase_en(phase_en), .phase_flip(phase_flip),
    .phase_shift(phase_shift)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge pclk);
    penable = 1'b1;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge pclk);
    penable = 1'b1;
    #1 d = prdata;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0;
  endtask

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      8'h00: return "R11";
      8'h04, 8'h08: return "R4";
      8'h0C: return "R6";
      8'h10: return "R7";
      default: return "R8";
    endcase
  endfunction

  localparam int NV = 15;
  localparam logic [72:0] VEC [NV] = '{
    {8'h00, 32'h00FABFA5, 32'h00FABFA5, 1'b0},
    {8'h00, 32'h00D1EFA7, 32'h00D1EFA7, 1'b0},
    {8'h00, 32'h00123FA6, 32'h00123FA6, 1'b1},
    {8'h00, 32'h00FAB123, 32'h00FAB123, 1'b1},
    {8'h04, 32'h96965321, 32'h00005321, 1'b0},
    {8'h04, 32'h12345321, 32'h00000000, 1'b1},
    {8'h08, 32'h96967654, 32'h00007654, 1'b0},
    {8'h08, 32'h9696FFFF, 32'h00007777, 1'b0},
    {8'h0C, 32'h636F6D61, 32'h636F6D61, 1'b0},
    {8'h0C, 32'h00000001, 32'h77616B65, 1'b1},
    {8'h10, 32'h00000AA0, 32'h00000AA0, 1'b0},
    {8'h10, 32'h00000ABF, 32'h00000ABF, 1'b0},
    {8'h10, 32'h00000AC0, 32'h00000ABF, 1'b1},
    {8'h14, 32'h00000AA7, 32'h00000007, 1'b0},
    {8'h14, 32'h00000557, 32'h00000008, 1'b1}
  };

  initial begin
    repeat (20000) @(posedge pclk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge pclk);
    presetn = 1'b1;
    @(negedge pclk);

    // R1 reset state
    check("R1 osc_en", 32'(osc_en), 32'd1);
    check("R1 range", {27'd0, range_sel, stage_first}, 32'd0);
    check("R1 drive", {8'd0, drive_hi, drive_lo}, 32'd0);
    check("R1 dormant", 32'(dormant_req), 32'd0);
    check("R1 div", 32'(div_val), 32'd16);
    check("R1 phase", {28'd0, phase_en, phase_flip, phase_shift}, 32'h8);
    apb_rd(8'h18, r);
    check("R1 bad flag", 32'(r[24]), 32'd0);
    apb_rd(8'h00, r);
    check("R11 ctl reset", r, 32'h000AA0);

    for (int i = 0; i < NV; i++) begin
      logic [72:0] v;
      v = VEC[i];
      apb_wr(v[72:65], v[64:33]);
      apb_rd(v[72:65], r);
      check(tag_of(v[72:65]), r, v[32:1]);
      apb_rd(8'h18, r);
      check({tag_of(v[72:65]), " bad-write"}, 32'(r[24]), 32'(v[0]));
      apb_wr(8'h18, 32'h0100_0000);
    end

    // R2
    apb_wr(8'h00, 32'h00D1EFA4);
    check("R2 disable", 32'(osc_en), 32'd0);
    apb_wr(8'h00, 32'h00777FA4);
    check("R2 invalid enables", 32'(osc_en), 32'd1);
    apb_wr(8'h18, 32'h0100_0000);

    // R3
    apb_wr(8'h00, 32'h00FABFA5);
    check("R3 medium", {29'd0, range_sel, stage_first[0]}, {29'd0, 2'd1, 1'b0});
    check("R3 medium first", 32'(stage_first), 32'd2);
    apb_wr(8'h00, 32'h00FABFA6);
    check("R3 toohigh", {27'd0, range_sel, stage_first}, {27'd0, 2'd3, 3'd6});
    apb_wr(8'h00, 32'h00FABFA7);
    check("R3 high", {27'd0, range_sel, stage_first}, {27'd0, 2'd2, 3'd4});
    apb_wr(8'h00, 32'h00FAB555);
    check("R3 invalid holds", {27'd0, range_sel, stage_first}, {27'd0, 2'd2, 3'd4});
    apb_rd(8'h18, r);
    check("R3 bad-write", 32'(r[24]), 32'd1);
    apb_wr(8'h18, 32'h0100_0000);

    // R4
    apb_wr(8'h04, 32'h96960123);
    check("R4 low bank", 32'(drive_lo), 32'h053);
    apb_wr(8'h08, 32'h96967000);
    check("R4 high bank", 32'(drive_hi), 32'hE00);

    // R5
    apb_wr(8'h04, 32'hABCD7777);
    check("R5 low zeroed", 32'(drive_lo), 32'h000);
    check("R5 high kept", 32'(drive_hi), 32'hE00);
    apb_wr(8'h18, 32'h0100_0000);

    // R6
    apb_wr(8'h0C, 32'h636F6D61);
    check("R6 sleep", 32'(dormant_req), 32'd1);
    apb_wr(8'h0C, 32'h77616B65);
    check("R6 wake", 32'(dormant_req), 32'd0);

    // R7
    apb_wr(8'h10, 32'h00000AA3);
    check("R7 div 3", 32'(div_val), 32'd3);
    apb_wr(8'h10, 32'h00000123);
    check("R7 div fallback", 32'(div_val), 32'd31);

    // R9 status word and clear behaviour (bad-write set by the previous write)
    osc_stable = 1'b1; div_running = 1'b1; osc_enabled = 1'b0;
    apb_rd(8'h18, r);
    check("R9 status", r, 32'h8101_0000);
    apb_wr(8'h18, 32'h0000_0000);
    apb_rd(8'h18, r);
    check("R9 write zero keeps", r, 32'h8101_0000);
    apb_wr(8'h18, 32'h0100_0000);
    osc_enabled = 1'b1;
    apb_rd(8'h18, r);
    check("R9 cleared", r, 32'h8001_1000);

    // R8
    apb_wr(8'h14, 32'h00000AA6);
    check("R8 keyed", {28'd0, phase_en, phase_flip, phase_shift}, 32'h6);
    apb_wr(8'h14, 32'h0000000B);
    check("R8 fallback", {28'd0, phase_en, phase_flip, phase_shift}, 32'h8);
    apb_wr(8'h18, 32'h0100_0000);

    // R10 unmapped and unaligned accesses
    apb_wr(8'h1C, 32'hFFFF_FFFF);
    apb_wr(8'h40, 32'h00D1EFA6);
    apb_wr(8'h01, 32'h00D1EFA6);
    check("R10 en untouched", 32'(osc_en), 32'd1);
    check("R10 range untouched", 32'(range_sel), 32'd2);
    apb_rd(8'h18, r);
    check("R10 no bad-write", 32'(r[24]), 32'd0);
    apb_rd(8'h1C, r);
    check("R10 read 0x1C", r, 32'd0);
    apb_rd(8'h40, r);
    check("R10 read 0x40", r, 32'd0);
    apb_rd(8'h11, r);
    check("R10 read unaligned", r, 32'd0);
    check("R10 handshake", {30'd0, pready, pslverr}, 32'h2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule